// File: doc/BRIEF.md
# Command-Mode Parallel Panel Frame Writer

This block sends one frame of pixel words to a command-mode LCD panel over a parallel bus with a write strobe. Each word gets its own chip-select cycle. Four programmable phase counts shape that cycle: chip-select setup, strobe setup, strobe low time and strobe hold. The panel keeps its own frame memory, so the block moves data only when told to. Software can start a frame by writing a trigger command. A rising edge on the panel's tearing-effect line can also start one, but only after software has marked that a new update is pending.

Pixel words arrive on a valid/ready stream, each with a register-select bit that is driven onto the RS pin. The frame length comes from an input and is captured at the start together with the timing. A trigger that arrives while a frame is moving is dropped, because a second trigger can reset the panel. At the end of the frame the block emits a one-cycle done pulse. It also sets a sticky done flag, which software clears by writing 1 and which drives the interrupt line when the interrupt enable is set.

Register map (write-only, selected by `cfg_addr`). Address 0 holds the timing: [19:16] CS setup, [15:12] WR setup, [11:8] WR active, [7:4] WR hold, [0] interface enable. At reset this register is 0x100, which gives setups of 0, an active time of 1 and a hold of 0. Address 1 is the trigger control: [0] selects command mode (1), and [1] is a software trigger that acts only when the same write also sets bit 0. Address 2 is the interrupt setup: [0] interrupt enable, and [1] sets the pending-update flag when written as 1. Address 3 is the status clear: writing 1 to [0] clears the done flag.

Top module: `panel_frame_writer`

## Requirements
- R1: After reset, cs_n, wr_n and the done flag are in their idle states (cs_n=1, wr_n=1, done_flag=0), and busy, irq and pix_ready are 0.
- R2: Each word holds cs_n low for exactly CS_setup + WR_setup + A + WR_hold cycles, where A is the active count, or 1 when the active count is 0. wr_n goes low CS_setup + WR_setup cycles after cs_n falls and stays low for A cycles. cs_n is high for at least one cycle between words.
- R3: An active count of 0 gives a strobe low time of one cycle.
- R4: DATA and RS stay constant while cs_n is low. They equal the accepted word and its register-select bit, in stream order.
- R5: A frame writes exactly the captured number of words. In the cycle after the last word's chip select rises, frame_done is high for one cycle and busy is 0.
- R6: A software trigger is ignored unless the interface enable (address 0 bit 0) is 1 and the trigger write also sets command mode (address 1 bit 0).
- R7: A trigger that arrives while busy is 1 is ignored, and no extra words follow the frame.
- R8: A tearing-effect rising edge starts a frame only while the pending flag is set and command mode is selected. Accepting a trigger clears the pending flag. A level held high does not retrigger.
- R9: The done flag is set at the end of a frame. It stays set until address 3 is written with bit 0 = 1, and irq is done_flag AND interrupt enable.
- R10: The timing and frame length in effect are those captured when the frame starts. Later writes affect only the next frame.
- R11: A trigger with a frame length of 0 is ignored.
- R12: pix_ready is 1 only between words of an active frame, never while cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| frame_words | input | FW | Words per frame, captured at start |
| te | input | 1 | Tearing-effect input from the panel |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Pixel word accepted when high with valid |
| pix_data | input | DW | Pixel word |
| pix_rs | input | 1 | Register-select bit for the word |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| rs | output | 1 | Panel register select |
| data | output | DW | Panel data bus |
| busy | output | 1 | Frame transfer in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| done_flag | output | 1 | Sticky done flag |
| irq | output | 1 | Masked done interrupt |

## Verification
The bench builds the block with a 16-bit data bus and an 8-bit frame length. With an 8-bit length, frames of a few words up to the full counter range take only a few hundred cycles. Every phase count is 4 bits wide, so the bench can drive both the all-zero timing and the all-15 timing, which gives the shortest and longest word cycles. It can also drive an active count of 0. The frame length of 0 is reachable as well.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

  localparam logic [1:0] A_TIMING = 2'd0;
  localparam logic [1:0] A_TRIG   = 2'd1;
  localparam logic [1:0] A_IRQ    = 2'd2;
  localparam logic [1:0] A_STAT   = 2'd3;

  typedef enum logic [2:0] {
    PH_GAP = 3'd0,
    PH_CSS = 3'd1,
    PH_WRS = 3'd2,
    PH_ACT = 3'd3,
    PH_HLD = 3'd4
  } phase_e;

  typedef struct packed {
    logic [3:0] css;
    logic [3:0] wrs;
    logic [3:0] act;
    logic [3:0] hld;
  } wtiming_t;

  localparam wtiming_t TIMING_RESET = '{css: 4'd0, wrs: 4'd0, act: 4'd1, hld: 4'd0};

  function automatic wtiming_t timing_from_word(input logic [31:0] w);
    return '{css: w[19:16], wrs: w[15:12], act: w[11:8], hld: w[7:4]};
  endfunction

  // strobe low time never shorter than one cycle
  function automatic logic [3:0] strobe_len(input logic [3:0] a);
    return (a == 4'd0) ? 4'd1 : a;
  endfunction

  function automatic logic [3:0] phase_len(input phase_e p, input wtiming_t t);
    case (p)
      PH_CSS:  return t.css;
      PH_WRS:  return t.wrs;
      PH_ACT:  return strobe_len(t.act);
      PH_HLD:  return t.hld;
      default: return 4'd0;
    endcase
  endfunction

  // next phase that has a nonzero length; the active phase always has one
  function automatic phase_e phase_after(input phase_e p, input wtiming_t t);
    case (p)
      PH_GAP:  return (t.css != 4'd0) ? PH_CSS : ((t.wrs != 4'd0) ? PH_WRS : PH_ACT);
      PH_CSS:  return (t.wrs != 4'd0) ? PH_WRS : PH_ACT;
      PH_WRS:  return PH_ACT;
      PH_ACT:  return (t.hld != 4'd0) ? PH_HLD : PH_GAP;
      default: return PH_GAP;
    endcase
  endfunction

  function automatic logic [5:0] word_cycles(input wtiming_t t);
    return 6'(t.css) + 6'(t.wrs) + 6'(strobe_len(t.act)) + 6'(t.hld);
  endfunction

endpackage

// File: rtl/pfw_regs.sv
module pfw_regs
  import pfw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        start,
  input  logic        frame_end,
  output wtiming_t    timing,
  output logic        if_en,
  output logic        cmd_mode,
  output logic        pending,
  output logic        sw_req,
  output logic        done_flag,
  output logic        irq
);

  logic irq_en;
  logic wr_timing, wr_trig, wr_irq, wr_stat;
  logic unused_bits;

  assign wr_timing = cfg_we && (cfg_addr == A_TIMING);
  assign wr_trig   = cfg_we && (cfg_addr == A_TRIG);
  assign wr_irq    = cfg_we && (cfg_addr == A_IRQ);
  assign wr_stat   = cfg_we && (cfg_addr == A_STAT);

  // software trigger counts only when the same write selects command mode
  assign sw_req = wr_trig && cfg_wdata[1] && cfg_wdata[0];
  assign unused_bits = ^{cfg_wdata[31:20], cfg_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing   <= TIMING_RESET;
      if_en    <= 1'b0;
      cmd_mode <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      if (wr_timing) begin
        timing <= timing_from_word(cfg_wdata);
        if_en  <= cfg_wdata[0];
      end
      if (wr_trig) cmd_mode <= cfg_wdata[0];
      if (wr_irq)  irq_en   <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (wr_irq && cfg_wdata[1]) begin
      pending <= 1'b1;
    end else if (start) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
    end else if (frame_end) begin
      done_flag <= 1'b1;
    end else if (wr_stat && cfg_wdata[0]) begin
      done_flag <= 1'b0;
    end
  end

  assign irq = done_flag && irq_en;

endmodule

// File: rtl/pfw_trig.sv
module pfw_trig
  import pfw_pkg::*;
#(
  parameter int unsigned FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          te,
  input  logic          if_en,
  input  logic          cmd_mode,
  input  logic          pending,
  input  logic          sw_req,
  input  logic [FW-1:0] frame_words,
  input  wtiming_t      timing,
  input  logic          word_end,
  output logic          start,
  output logic          frame_end,
  output logic          busy,
  output logic          frame_done,
  output wtiming_t      tim_snap
);

  logic          te_q;
  logic          te_rise;
  logic          hw_req;
  logic [FW-1:0] left;

  assign te_rise   = te && !te_q;
  assign hw_req    = te_rise && pending && cmd_mode;
  assign start     = if_en && !busy && (frame_words != '0) && (sw_req || hw_req);
  assign frame_end = busy && word_end && (left == FW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) te_q <= 1'b0;
    else        te_q <= te;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      frame_done <= 1'b0;
      left       <= '0;
      tim_snap   <= TIMING_RESET;
    end else begin
      frame_done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        left     <= frame_words;
        tim_snap <= timing;
      end else if (frame_end) begin
        busy       <= 1'b0;
        frame_done <= 1'b1;
        left       <= '0;
      end else if (busy && word_end) begin
        left <= left - FW'(1);
      end
    end
  end

endmodule

// File: rtl/pfw_strobe.sv
module pfw_strobe
  import pfw_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  wtiming_t      tim,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_rs,
  output logic          cs_n,
  output logic          wr_n,
  output logic          rs,
  output logic [DW-1:0] data,
  output logic          word_end
);

  phase_e        state;
  phase_e        nxt;
  logic [3:0]    cnt;
  logic          take;
  logic          phase_last;
  logic [DW-1:0] dat_q;
  logic          rs_q;

  assign pix_ready  = run && (state == PH_GAP);
  assign take       = pix_valid && pix_ready;
  assign phase_last = (state != PH_GAP) && (cnt == 4'd1);
  assign nxt        = phase_after(take ? PH_GAP : state, tim);
  assign word_end   = phase_last && (nxt == PH_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_GAP;
      cnt   <= 4'd0;
      dat_q <= '0;
      rs_q  <= 1'b0;
    end else if (take) begin
      state <= nxt;
      cnt   <= phase_len(nxt, tim);
      dat_q <= pix_data;
      rs_q  <= pix_rs;
    end else if (phase_last) begin
      state <= nxt;
      cnt   <= phase_len(nxt, tim);
    end else if (state != PH_GAP) begin
      cnt <= cnt - 4'd1;
    end
  end

  assign cs_n = (state == PH_GAP);
  assign wr_n = (state != PH_ACT);
  assign rs   = rs_q;
  assign data = dat_q;

endmodule

// File: rtl/panel_frame_writer.sv
module panel_frame_writer
  import pfw_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic [FW-1:0] frame_words,
  input  logic          te,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_rs,
  output logic          cs_n,
  output logic          wr_n,
  output logic          rs,
  output logic [DW-1:0] data,
  output logic          busy,
  output logic          frame_done,
  output logic          done_flag,
  output logic          irq
);

  wtiming_t timing;
  wtiming_t tim_snap;
  logic     if_en, cmd_mode, pending, sw_req;
  logic     start, frame_end, word_end;

  pfw_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .start     (start),
    .frame_end (frame_end),
    .timing    (timing),
    .if_en     (if_en),
    .cmd_mode  (cmd_mode),
    .pending   (pending),
    .sw_req    (sw_req),
    .done_flag (done_flag),
    .irq       (irq)
  );

  pfw_trig #(.FW(FW)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .te          (te),
    .if_en       (if_en),
    .cmd_mode    (cmd_mode),
    .pending     (pending),
    .sw_req      (sw_req),
    .frame_words (frame_words),
    .timing      (timing),
    .word_end    (word_end),
    .start       (start),
    .frame_end   (frame_end),
    .busy        (busy),
    .frame_done  (frame_done),
    .tim_snap    (tim_snap)
  );

  pfw_strobe #(.DW(DW)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .tim       (tim_snap),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_data  (pix_data),
    .pix_rs    (pix_rs),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rs        (rs),
    .data      (data),
    .word_end  (word_end)
  );

endmodule

// File: rtl/pfw_checker.sv
module pfw_checker
  import pfw_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic [31:0]   cfg_wdata,
  input logic          cs_n,
  input logic          wr_n,
  input logic          rs,
  input logic [DW-1:0] data,
  input logic          pix_ready,
  input logic          busy,
  input logic          frame_done,
  input logic          done_flag,
  input logic          irq,
  input logic          word_end,
  input wtiming_t      tim_snap
);

  logic [5:0] cs_run;
  logic       clr_w1c;

  assign clr_w1c = cfg_we && (cfg_addr == A_STAT) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cs_run <= '0;
    else if (cs_n) cs_run <= '0;
    else           cs_run <= cs_run + 6'd1;
  end

  AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);  // R2

  AST_WORD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |-> (cs_run + 6'd1 == word_cycles(tim_snap)));  // R2

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(data) && $stable(rs)));  // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);  // R5

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!busy && $past(busy)));  // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_w1c) |=> done_flag);  // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);  // R9

  AST_READY_OUTSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (cs_n && busy));  // R12

endmodule

bind panel_frame_writer pfw_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .cs_n       (cs_n),
  .wr_n       (wr_n),
  .rs         (rs),
  .data       (data),
  .pix_ready  (pix_ready),
  .busy       (busy),
  .frame_done (frame_done),
  .done_flag  (done_flag),
  .irq        (irq),
  .word_end   (word_end),
  .tim_snap   (tim_snap)
);

// File: tb/sim_panel_frame_writer.sv
`timescale 1ns/1ps
module sim_panel_frame_writer;

  localparam int DW = 16;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [FW-1:0] frame_words = '0;
  logic          te = 1'b0;
  logic          pix_valid = 1'b0;
  logic          pix_ready;
  logic [DW-1:0] pix_data = '0;
  logic          pix_rs = 1'b0;
  logic          cs_n, wr_n, rs, busy, frame_done, done_flag, irq;
  logic [DW-1:0] data;

  always #10 clk = ~clk;

  panel_frame_writer #(.DW(DW), .FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_words(frame_words), .te(te),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_rs(pix_rs), .cs_n(cs_n), .wr_n(wr_n), .rs(rs), .data(data),
    .busy(busy), .frame_done(frame_done), .done_flag(done_flag), .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // word records collected by the monitor
  int rec_n = 0;
  int rec_cs[64];
  int rec_wr[64];
  int rec_off[64];
  int rec_dat[64];
  int rec_rs[64];
  int rec_stab[64];
  int min_gap = 1000;
  int done_cnt = 0;
  int done_busy_bad = 0;
  int ready_bad = 0;
  int busy_seen = 0;

  // pixel source state
  logic          src_on = 1'b0;
  logic [DW-1:0] src_base = '0;
  int            src_idx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor
  initial begin
    bit prev_cs = 1'b1;
    int run = 0, wrl = 0, off = -1, d0 = 0, r0 = 0, stab = 1, gap = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_cs = 1'b1;
      end else begin
        if (!cs_n) begin
          if (prev_cs) begin
            if (rec_n > 0 && gap < min_gap) min_gap = gap;
            run = 0; wrl = 0; off = -1; d0 = int'(data); r0 = int'(rs); stab = 1;
          end
          run++;
          if (!wr_n) begin
            if (off < 0) off = run - 1;
            wrl++;
          end
          if (int'(data) != d0 || int'(rs) != r0) stab = 0;
          if (pix_ready) ready_bad++;
        end else begin
          if (!prev_cs && rec_n < 64) begin
            rec_cs[rec_n] = run; rec_wr[rec_n] = wrl; rec_off[rec_n] = off;
            rec_dat[rec_n] = d0; rec_rs[rec_n] = r0; rec_stab[rec_n] = stab;
            rec_n++;
            gap = 0;
          end
          gap++;
        end
        if (frame_done) begin
          done_cnt++;
          if (busy) done_busy_bad++;
        end
        if (busy) busy_seen++;
        prev_cs = cs_n;
      end
    end
  end

  // pixel source: word k carries src_base+k, rs = k[0]
  initial begin
    bit xfer = 1'b0;
    forever begin
      @(negedge clk);
      if (xfer) src_idx++;
      pix_valid = src_on;
      pix_data  = src_base + DW'(src_idx);
      pix_rs    = src_idx[0];
      xfer      = pix_valid && pix_ready;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] tword(input int css, input int wrs, input int act,
                                        input int hld, input bit en);
    return (32'(css) << 16) | (32'(wrs) << 12) | (32'(act) << 8) | (32'(hld) << 4) | 32'(en);
  endfunction

  task automatic clear_mon(input logic [DW-1:0] base);
    rec_n = 0; done_cnt = 0; done_busy_bad = 0; busy_seen = 0; min_gap = 1000;
    src_base = base; src_idx = 0; src_on = 1'b1;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!frame_done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  // verify n records against one timing set
  task automatic check_words(input string tag, input int n, input int css, input int wrs,
                             input int act, input int hld, input logic [DW-1:0] base);
    int a1 = (act == 0) ? 1 : act;
    int exp_cs = css + wrs + a1 + hld;
    int bad_len = 0, bad_wr = 0, bad_off = 0, bad_dat = 0, bad_stab = 0;
    for (int k = 0; k < rec_n && k < 64; k++) begin
      if (rec_cs[k] != exp_cs) bad_len++;
      if (rec_wr[k] != a1) bad_wr++;
      if (rec_off[k] != css + wrs) bad_off++;
      if (rec_dat[k] != int'(DW'(base + DW'(k))) || rec_rs[k] != (k % 2)) bad_dat++;
      if (rec_stab[k] != 1) bad_stab++;
    end
    chk(rec_n == n, {tag, " R5 word count"}, rec_n, n);
    chk(bad_len == 0, {tag, " R2 cs low length"}, (rec_n > 0) ? rec_cs[0] : -1, exp_cs);
    chk(bad_off == 0, {tag, " R2 wr fall offset"}, (rec_n > 0) ? rec_off[0] : -1, css + wrs);
    chk(bad_wr == 0, {tag, " R2 R3 wr low length"}, (rec_n > 0) ? rec_wr[0] : -1, a1);
    chk(bad_dat == 0, {tag, " R4 data and rs order"}, bad_dat, 0);
    chk(bad_stab == 0, {tag, " R4 bus stable"}, bad_stab, 0);
    if (n > 1) chk(min_gap >= 1 && min_gap < 1000, {tag, " R2 cs gap"}, min_gap, 1);
    chk(done_cnt == 1, {tag, " R5 one done pulse"}, done_cnt, 1);
    chk(done_busy_bad == 0, {tag, " R5 busy low at done"}, done_busy_bad, 0);
  endtask

  task automatic t_frame(input string tag, input int css, input int wrs, input int act,
                         input int hld, input int n, input logic [DW-1:0] base);
    wr_reg(2'd0, tword(css, wrs, act, hld, 1'b1));
    frame_words = FW'(n);
    clear_mon(base);
    wr_reg(2'd1, 32'h3);
    wait_done();
    check_words(tag, n, css, wrs, act, hld, base);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1'b1 && wr_n == 1'b1, "R1 idle strobes", {cs_n, wr_n}, 3);
    chk(busy == 1'b0 && pix_ready == 1'b0, "R1 not busy", {busy, pix_ready}, 0);
    chk(irq == 1'b0 && done_flag == 1'b0, "R1 no done", {irq, done_flag}, 0);
  endtask

  task automatic t_ignored_sw();
    clear_mon(16'h0);
    frame_words = FW'(3);
    wr_reg(2'd0, tword(0, 0, 1, 0, 1'b0));
    wr_reg(2'd1, 32'h3);
    repeat (20) @(negedge clk);
    chk(busy_seen == 0 && rec_n == 0, "R6 disabled trigger ignored", rec_n, 0);
    wr_reg(2'd0, tword(0, 0, 1, 0, 1'b1));
    wr_reg(2'd1, 32'h2);
    repeat (20) @(negedge clk);
    chk(busy_seen == 0 && rec_n == 0, "R6 trigger without command mode ignored", rec_n, 0);
  endtask

  task automatic t_zero_len();
    clear_mon(16'h0);
    frame_words = '0;
    wr_reg(2'd0, tword(0, 0, 1, 0, 1'b1));
    wr_reg(2'd1, 32'h3);
    repeat (20) @(negedge clk);
    chk(busy_seen == 0 && rec_n == 0 && done_cnt == 0, "R11 zero length ignored", busy_seen, 0);
  endtask

  task automatic t_retrigger();
    wr_reg(2'd0, tword(2, 1, 3, 1, 1'b1));
    frame_words = FW'(4);
    clear_mon(16'h4000);
    wr_reg(2'd1, 32'h3);
    repeat (5) @(negedge clk);
    wr_reg(2'd1, 32'h3);
    repeat (10) @(negedge clk);
    wr_reg(2'd1, 32'h3);
    wait_done();
    repeat (40) @(negedge clk);
    chk(rec_n == 4, "R7 retrigger while busy ignored", rec_n, 4);
    chk(done_cnt == 1, "R7 single frame done", done_cnt, 1);
  endtask

  task automatic t_snapshot();
    wr_reg(2'd0, tword(2, 2, 2, 2, 1'b1));
    frame_words = FW'(3);
    clear_mon(16'h1230);
    wr_reg(2'd1, 32'h3);
    repeat (3) @(negedge clk);
    wr_reg(2'd0, tword(0, 0, 1, 0, 1'b1));
    frame_words = FW'(9);
    wait_done();
    check_words("R10 snapshot", 3, 2, 2, 2, 2, 16'h1230);
  endtask

  task automatic te_pulse();
    @(negedge clk); te = 1'b1;
    repeat (2) @(negedge clk); te = 1'b0;
  endtask

  task automatic t_te();
    wr_reg(2'd0, tword(1, 0, 2, 0, 1'b1));
    frame_words = FW'(5);
    wr_reg(2'd1, 32'h1);
    clear_mon(16'h0500);
    te_pulse();
    repeat (20) @(negedge clk);
    chk(busy_seen == 0 && rec_n == 0, "R8 te without pending ignored", rec_n, 0);
    wr_reg(2'd2, 32'h2);
    @(negedge clk); te = 1'b1;
    wait_done();
    repeat (30) @(negedge clk);
    chk(rec_n == 5 && done_cnt == 1, "R8 te with pending runs one frame", rec_n, 5);
    te = 1'b0;
    clear_mon(16'h0500);
    te_pulse();
    repeat (20) @(negedge clk);
    chk(busy_seen == 0 && rec_n == 0, "R8 pending cleared by accepted trigger", rec_n, 0);
  endtask

  task automatic t_done_irq();
    wr_reg(2'd2, 32'h0);
    wr_reg(2'd3, 32'h1);
    @(negedge clk);
    chk(done_flag == 1'b0, "R9 w1c clears", done_flag, 0);
    t_frame("R9 frame", 0, 0, 1, 0, 2, 16'h0900);
    chk(done_flag == 1'b1 && irq == 1'b0, "R9 sticky set, irq masked", {done_flag, irq}, 2);
    wr_reg(2'd2, 32'h1);
    chk(irq == 1'b1, "R9 irq when enabled", irq, 1);
    wr_reg(2'd3, 32'h0);
    chk(done_flag == 1'b1, "R9 write 0 keeps flag", done_flag, 1);
    wr_reg(2'd3, 32'h1);
    chk(done_flag == 1'b0 && irq == 1'b0, "R9 write 1 clears flag and irq", {done_flag, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame("R2 default timing", 0, 0, 1, 0, 4, 16'h0100);
    t_frame("R2 mixed timing", 2, 1, 3, 2, 5, 16'h0200);
    t_frame("R3 zero active", 1, 0, 0, 1, 3, 16'h0300);
    t_frame("R2 max timing", 15, 15, 15, 15, 2, 16'hFFFE);
    t_frame("R5 full length", 0, 1, 1, 0, 40, 16'h7000);
    t_ignored_sw();
    t_zero_len();
    t_retrigger();
    t_snapshot();
    t_te();
    t_done_irq();
    chk(ready_bad == 0, "R12 ready never during cs", ready_bad, 0);
    summary();
  end

endmodule